// File: doc/BRIEF.md
# Telemetry Transmit FIFO Controller

This block is the transmit-side buffer of a synchronous telemetry serial port. A processor writes 16-bit words over a simple 32-bit register bus, and each word is stored as two bytes, high byte first. A downstream serial engine removes data one 16-bit word at a time through a single-cycle pop strobe. The first byte removed lands in the upper half of the returned word.

Next to the byte queue the block keeps several registers:
- a status register;
- a running frame count, in fixed-size frames of written bytes;
- an occupancy readback in bytes;
- a bit-clock divider, with the bit rate equal to the input clock over 2×(divider+1);
- a scrambler-enable register;
- a soft-reset register.

A pulsed interrupt tells software that the queue is running low, once at least one complete frame has been written. Writing enough data to pass a high watermark withdraws that pulse. The bit shifter, the scrambling polynomial and any receive path are outside this block.

Top module: `tlm_tx_buffer`

## Requirements
- R1: A write to offset 0x00 stores bits 15:8 as one byte and then bits 7:0 as the next byte. A pop returns the next two bytes in first-in order, the earlier byte in bits 15:8, on `pop_word` in the cycle after the pop.
- R2: A pop while the queue is empty returns 0 on `pop_word` and leaves occupancy and frame count unchanged.
- R3: A data write while fewer than 2 bytes are free is dropped whole and sets status bit 2. The next pop clears bit 2.
- R4: The status register at 0x04 reads bit 0 = queue empty, bit 1 = at least half the capacity occupied, bit 2 = dropped write, bit 3 = transmitter idle. It reads 0x09 after reset. Idle is set by reset and by a pop that empties the queue, and is cleared by a pop that leaves data behind.
- R5: The register at 0x0C reads the number of bytes stored. Every register read returns its value on `bus_rdata` in the cycle after `bus_rd`.
- R6: The register at 0x08 reads the total number of accepted bytes since reset, divided by the frame size (2^FRAME_LOG2 bytes). Pops do not lower it.
- R7: A pop that leaves fewer than LOW_MARK bytes, while the frame count is nonzero, raises `irq` for exactly IRQ_LEN cycles, starting in the cycle after the pop. No pulse is raised while the frame count is zero.
- R8: An accepted write that brings occupancy above HIGH_MARK bytes drops `irq` in the next cycle.
- R9: Writing 0x55 to offset 0x7C empties the queue, zeroes the counters, sets status to 0x09, returns the divider to DIV_DEFAULT (731), clears the scrambler and reset registers and drops `irq`. Any other value is only stored and reads back at 0x7C.
- R10: The divider at 0x10 (16 bits) reads back and drives `bit_div`. The register at 0x14 reads back, and `scramble_on` is 1 exactly when it holds 0x55.
- R11: Reads of 0x00 or of unmapped offsets return 0. Writes to 0x04, 0x08, 0x0C or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte offset within the 0x80 window |
| bus_wdata | input | 32 | Write data (data register uses bits 15:0) |
| bus_rdata | output | 32 | Registered read data |
| pop | input | 1 | Serial engine word request |
| pop_word | output | 16 | Registered popped word |
| irq | output | 1 | Low-watermark interrupt pulse |
| bit_div | output | 16 | Bit-clock divider value |
| scramble_on | output | 1 | Scrambler enable |

## Verification
The bench builds the block with a 64-byte queue, 16-byte frames, watermarks of 8 and 12 bytes and a 12-cycle interrupt pulse. With these values, filling the queue, overflowing it, crossing the half mark and completing several frames each take a few dozen operations. The random mix therefore reaches the full and empty edges many times. The pulse is long enough that expiry and high-watermark cancellation fall in different cycles, so the two can be told apart.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef logic [6:0] reg_off_t;

  localparam reg_off_t OFF_DATA  = 7'h00;
  localparam reg_off_t OFF_STAT  = 7'h04;
  localparam reg_off_t OFF_FRAME = 7'h08;
  localparam reg_off_t OFF_OCC   = 7'h0C;
  localparam reg_off_t OFF_DIV   = 7'h10;
  localparam reg_off_t OFF_SCR   = 7'h14;
  localparam reg_off_t OFF_RST   = 7'h7C;

  localparam logic [7:0] KEY_MAGIC = 8'h55;

  localparam int ST_EMPTY = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_DROP  = 2;
  localparam int ST_IDLE  = 3;
endpackage

// File: rtl/tlm_word_fifo.sv
module tlm_word_fifo #(
  parameter int WORDS = 1024,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(WORDS));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= pop_ok ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(WORDS - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(WORDS - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(WORDS));

  assert_drop_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> $stable(count));

  assert_empty_pop_no_change_R2: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/tlm_byte_counter.sv
module tlm_byte_counter #(
  parameter int FRAME_LOG2 = 10,
  parameter int FRAME_W    = 16,
  localparam int BW = FRAME_W + FRAME_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  output logic [FRAME_W-1:0] frames
);
  logic [BW-1:0] byte_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) byte_cnt <= '0;
    else if (inc)   byte_cnt <= byte_cnt + BW'(2);
  end

  assign frames = byte_cnt[BW-1:FRAME_LOG2];

  assert_frame_step_R6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (frames == $past(frames) || frames == $past(frames) + 1'b1));

  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(frames));
endmodule

// File: rtl/tlm_irq_pulse.sv
module tlm_irq_pulse #(
  parameter int LEN = 24,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic kill,
  output logic irq
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || kill)          remain <= '0;
    else if (start)           remain <= CW'(LEN);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign irq = (remain != '0);

  assert_kill_drops_R8: assert property (@(posedge clk) disable iff (rst)
    kill |=> !irq);

  assert_start_raises_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !kill) |=> irq);
endmodule

// File: rtl/tlm_tx_buffer.sv
module tlm_tx_buffer
  import tlm_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int FRAME_LOG2  = 10,
  parameter int FRAME_W     = 16,
  parameter int LOW_MARK    = 64,
  parameter int HIGH_MARK   = 96,
  parameter int IRQ_LEN     = 24,
  parameter int DIV_W       = 16,
  parameter int DIV_DEFAULT = 731,
  localparam int WORDS = DEPTH_BYTES / 2,
  localparam int CW    = $clog2(WORDS) + 1,
  localparam int OCC_W = CW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             pop,
  output logic [15:0]      pop_word,
  output logic             irq,
  output logic [DIV_W-1:0] bit_div,
  output logic             scramble_on
);
  logic             soft_clr, push_req, push_ok, drop, pop_ok;
  logic             fifo_empty, fifo_full;
  logic [CW-1:0]    fifo_count, cnt_next;
  logic [OCC_W-1:0] occ_bytes, occ_next;
  logic [FRAME_W-1:0] frames;
  logic             irq_start, irq_kill;
  logic             drop_f, idle_f;
  logic [7:0]       scr_q, rst_q;
  logic [3:0]       status_vec;
  logic             wire_unused;

  assign wire_unused = ^bus_wdata[31:DIV_W];

  // write decode
  assign soft_clr = bus_wr && (bus_addr == OFF_RST) && (bus_wdata[7:0] == KEY_MAGIC);
  assign push_req = bus_wr && (bus_addr == OFF_DATA);
  assign push_ok  = push_req && !fifo_full;
  assign drop     = push_req && fifo_full;
  assign pop_ok   = pop && !fifo_empty;

  tlm_word_fifo #(.WORDS(WORDS), .WIDTH(16)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_clr),
    .push      (push_req),
    .push_data (bus_wdata[15:0]),
    .pop       (pop),
    .pop_data  (pop_word),
    .count     (fifo_count),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  tlm_byte_counter #(.FRAME_LOG2(FRAME_LOG2), .FRAME_W(FRAME_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (soft_clr),
    .inc    (push_ok),
    .frames (frames)
  );

  // occupancy in bytes, now and after this cycle
  assign cnt_next  = fifo_count + CW'(push_ok) - CW'(pop_ok);
  assign occ_bytes = {fifo_count, 1'b0};
  assign occ_next  = {cnt_next, 1'b0};

  assign irq_start = pop_ok && (frames != '0) && (occ_next < OCC_W'(LOW_MARK));
  assign irq_kill  = soft_clr || (push_ok && (occ_next > OCC_W'(HIGH_MARK)));

  tlm_irq_pulse #(.LEN(IRQ_LEN)) irq_i (
    .clk   (clk),
    .rst   (rst),
    .start (irq_start),
    .kill  (irq_kill),
    .irq   (irq)
  );

  // status flags kept in registers
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      drop_f <= 1'b0;
      idle_f <= 1'b1;
    end else begin
      if (drop)     drop_f <= 1'b1;
      else if (pop) drop_f <= 1'b0;
      if (pop_ok)   idle_f <= (cnt_next == '0);
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      bit_div     <= DIV_W'(DIV_DEFAULT);
      scr_q       <= '0;
      scramble_on <= 1'b0;
      rst_q       <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_DIV: bit_div <= bus_wdata[DIV_W-1:0];
        OFF_SCR: begin
          scr_q       <= bus_wdata[7:0];
          scramble_on <= (bus_wdata[7:0] == KEY_MAGIC);
        end
        OFF_RST: rst_q <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    status_vec           = '0;
    status_vec[ST_EMPTY] = fifo_empty;
    status_vec[ST_HALF]  = (occ_bytes >= OCC_W'(DEPTH_BYTES / 2));
    status_vec[ST_DROP]  = drop_f;
    status_vec[ST_IDLE]  = idle_f;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_STAT:  bus_rdata <= 32'(status_vec);
        OFF_FRAME: bus_rdata <= 32'(frames);
        OFF_OCC:   bus_rdata <= 32'(occ_bytes);
        OFF_DIV:   bus_rdata <= 32'(bit_div);
        OFF_SCR:   bus_rdata <= 32'(scr_q);
        OFF_RST:   bus_rdata <= 32'(rst_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (occ_bytes == '0 && frames == '0 && bit_div == DIV_W'(DIV_DEFAULT) && !irq));

  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> idle_f);

  assert_drop_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (push_req && fifo_full && !soft_clr) |=> status_vec[ST_DROP]);

  assert_scramble_key_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_SCR) |=> (scramble_on == ($past(bus_wdata[7:0]) == KEY_MAGIC)));
endmodule

// File: tb/tlm_tx_buffer_tb_top.sv
`timescale 1ns/1ps
module tlm_tx_buffer_tb_top;
  localparam int DEPTH  = 64;
  localparam int FLOG   = 4;
  localparam int LOWM   = 8;
  localparam int HIGHM  = 12;
  localparam int PLEN   = 12;
  localparam int DIVDEF = 731;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, pop = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pop_word, bit_div;
  logic        irq, scramble_on;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] m_q[$];
  int  m_written = 0;
  bit  m_drop = 0;
  bit  m_idle = 1;

  always #2.5 clk = ~clk;

  tlm_tx_buffer #(
    .DEPTH_BYTES(DEPTH), .FRAME_LOG2(FLOG), .FRAME_W(16), .LOW_MARK(LOWM),
    .HIGH_MARK(HIGHM), .IRQ_LEN(PLEN), .DIV_W(16), .DIV_DEFAULT(DIVDEF)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pop(pop), .pop_word(pop_word),
    .irq(irq), .bit_div(bit_div), .scramble_on(scramble_on)
  );

  function automatic logic [31:0] exp_status();
    return {28'd0, m_idle, m_drop, (m_q.size() >= DEPTH / 2), (m_q.size() == 0)};
  endfunction

  function automatic logic [31:0] exp_frames();
    return 32'(m_written >> FLOG);
  endfunction

  function automatic void model_soft_reset();
    m_q.delete();
    m_written = 0;
    m_drop = 0;
    m_idle = 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_write(logic [6:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_word(logic [15:0] d);
    bus_write(7'h00, {16'hDEAD, d});
    if (m_q.size() + 2 <= DEPTH) begin
      m_q.push_back(d[15:8]);
      m_q.push_back(d[7:0]);
      m_written += 2;
    end else begin
      m_drop = 1;
    end
  endtask

  task automatic pop_check(string req);
    logic [15:0] exp;
    pop = 1'b1;
    tick();
    pop = 1'b0;
    if (m_q.size() >= 2) begin
      exp[15:8] = m_q.pop_front();
      exp[7:0]  = m_q.pop_front();
      m_idle = (m_q.size() == 0);
    end else begin
      exp = 16'h0000;
    end
    m_drop = 0;
    chk(req, 32'(pop_word), 32'(exp));
  endtask

  task automatic check_regs(string req);
    logic [31:0] v;
    bus_read(7'h04, v); chk({req, " status"}, v, exp_status());
    bus_read(7'h0C, v); chk({req, " occupancy"}, v, 32'(m_q.size()));
    bus_read(7'h08, v); chk({req, " frames"}, v, exp_frames());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R4 / R9 reset state
    bus_read(7'h04, v); chk("R4 reset status", v, 32'h09);
    chk("R9 reset divider", 32'(bit_div), 32'(DIVDEF));
    chk("R10 reset scramble", 32'(scramble_on), 0);
    chk("R7 reset irq", 32'(irq), 0);

    // R1 byte order
    push_word(16'hABCD);
    pop_check("R1 single word");
    bus_read(7'h04, v); chk("R4 drained status", v, 32'h09);

    // R2 empty pop
    pop_check("R2 empty pop returns zero");
    check_regs("R2 after empty pop");

    // R1 / R5 order and occupancy, idle bit behaviour
    push_word(16'h1122); push_word(16'h3344); push_word(16'h5566);
    check_regs("R5 three words");
    pop_check("R1 first of three");
    bus_read(7'h04, v); chk("R4 busy status", v, 32'h00);
    pop_check("R1 second of three");
    pop_check("R1 third of three");

    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 100);
      int wr_pct = (i < 300) ? 65 : 30;
      if (r < wr_pct) push_word(16'($urandom));
      else if (r < wr_pct + 25) pop_check("R1 random pop");
      else check_regs("R4 random");
    end

    // R3 / R4 / R6 fill to full
    bus_write(7'h7C, 32'h55); model_soft_reset();
    for (int i = 0; i < 15; i++) push_word(16'(i * 257 + 3));
    bus_read(7'h04, v); chk("R4 below half", v, 32'h08);
    push_word(16'h0F0F);
    bus_read(7'h04, v); chk("R4 at half", v, 32'h0A);
    for (int i = 0; i < 16; i++) push_word(16'(i * 31 + 7));
    push_word(16'hBEEF);
    check_regs("R3 dropped write");
    bus_read(7'h04, v); chk("R3 drop flag set", v[2], 1);
    bus_read(7'h08, v); chk("R6 four frames", v, 32'd4);
    pop_check("R3 pop after drop");
    bus_read(7'h04, v); chk("R3 drop flag cleared", v[2], 0);
    bus_read(7'h08, v); chk("R6 pops keep frames", v, 32'd4);

    // R7 low watermark pulse
    for (int i = 0; i < 27; i++) pop_check("R1 drain");
    chk("R7 no pulse at mark", 32'(irq), 0);
    pop_check("R7 cross low mark");
    chk("R7 pulse starts", 32'(irq), 1);
    repeat (PLEN - 1) tick();
    chk("R7 pulse still high", 32'(irq), 1);
    tick();
    chk("R7 pulse ends", 32'(irq), 0);

    // R8 high watermark cancel
    pop_check("R8 pop below mark");
    chk("R8 pulse raised", 32'(irq), 1);
    for (int i = 0; i < 4; i++) push_word(16'(i + 16'h4000));
    chk("R8 pulse kept at mark", 32'(irq), 1);
    push_word(16'h5000);
    chk("R8 pulse cancelled", 32'(irq), 0);

    // R7 no pulse before first frame
    bus_write(7'h7C, 32'h55); model_soft_reset();
    push_word(16'h0102); push_word(16'h0304);
    pop_check("R7 frame zero pop");
    chk("R7 no pulse frame zero", 32'(irq), 0);

    // R10 divider and scrambler
    bus_write(7'h10, 32'h0000_1234);
    chk("R10 divider port", 32'(bit_div), 32'h1234);
    bus_read(7'h10, v); chk("R10 divider read", v, 32'h1234);
    bus_write(7'h14, 32'h55);
    chk("R10 scramble on", 32'(scramble_on), 1);
    bus_read(7'h14, v); chk("R10 scramble read", v, 32'h55);
    bus_write(7'h14, 32'h54);
    chk("R10 scramble off", 32'(scramble_on), 0);
    bus_write(7'h14, 32'h55);

    // R11 read-only and unmapped
    bus_write(7'h04, 32'hFF); bus_write(7'h08, 32'hFF);
    bus_write(7'h0C, 32'hFF); bus_write(7'h20, 32'hFF);
    check_regs("R11 ignored writes");
    bus_read(7'h20, v); chk("R11 unmapped read", v, 0);
    bus_read(7'h00, v); chk("R11 data read", v, 0);
    chk("R11 divider untouched", 32'(bit_div), 32'h1234);

    // R9 soft reset register
    bus_write(7'h7C, 32'h33);
    bus_read(7'h7C, v); chk("R9 plain value stored", v, 32'h33);
    check_regs("R9 plain value no reset");
    bus_write(7'h7C, 32'h55); model_soft_reset();
    check_regs("R9 after key");
    chk("R9 divider default", 32'(bit_div), 32'(DIVDEF));
    chk("R9 scramble cleared", 32'(scramble_on), 0);
    bus_read(7'h7C, v); chk("R9 reset reg cleared", v, 0);
    bus_read(7'h14, v); chk("R9 scramble reg cleared", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule